// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block converts a 16-bit logical address into a physical address. It uses one flat page table stored in ordinary memory. Pages are 4 KiB, so the top four address bits select one of sixteen table entries and the low twelve bits pass through untouched. A requester presents an address with an access kind (read, write or execute). The block then fetches the matching entry over a small memory port and checks it. It answers with either a physical address plus the entry's attributes, or a fault code.

The table is located by a base register and bounded by a limit register, both sampled when a request is accepted. When an access succeeds, the block marks the entry as referenced, and also as dirty if the access was a write. If that changes the entry, the block writes the entry back over the same port before answering. The block handles one translation at a time. It takes a new request only while idle, so the requester simply waits for the acknowledge pulse.

Top module: `pt_translator`

## Requirements
- R1: On success the physical address is the entry's frame number placed above the logical address's unchanged 12-bit offset; logical 0x3005 with page 3 mapped to frame 9 gives 0x9005.
- R2: The entry is read from word address `ptbr + page number`, where the page number is logical address bits 15..12, with exactly one read per translation that passes the limit check.
- R3: A page number greater than or equal to `ptlr` yields fault code 1 (limit) with no memory access, and `ack` is seen after the first rising edge counting the accepting one.
- R4: An entry with bit 0 (present) clear yields fault code 2 (not present), whatever its permission bits, and is never written back.
- R5: Access code 0 (read) needs entry bit 1, code 1 (write) needs bit 2, code 2 (execute) needs bit 3, and code 3 is always refused; a refused access on a present entry yields fault code 3 (permission) without write-back.
- R6: A successful access sets bit 4 (referenced), and a successful write also sets bit 5 (dirty). The updated entry is written to the same address only when it differs from the fetched one.
- R7: Each translation gives exactly one single-cycle `ack`. Counting rising edges from the accepting one, `ack` is seen after 3 edges without write-back and after 4 with write-back. While busy, `req` is ignored.
- R8: After reset, `ack`, `mem_rd_en` and `mem_wr_en` are low and the block is idle.
- R9: `resp_pte` carries the updated entry on success, the entry as fetched on fault codes 2 and 3, and zero on fault code 1. Bit 6 (cache disable) and bits 10..7 (frame) come back unaltered, and `resp_paddr` is zero on any fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Translation request, accepted when idle |
| req_vaddr | input | 16 | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| ptbr | input | 16 | Word address of table entry 0 |
| ptlr | input | 5 | Number of valid table entries (0 to 16) |
| mem_rd_en | output | 1 | Entry read strobe; data returns on the next cycle |
| mem_wr_en | output | 1 | Entry write-back strobe |
| mem_addr | output | 16 | Entry word address |
| mem_wdata | output | 11 | Updated entry for write-back |
| mem_rdata | input | 11 | Entry read data, valid the cycle after `mem_rd_en` |
| ack | output | 1 | One-cycle completion pulse |
| resp_paddr | output | 16 | Physical address, zero on a fault |
| resp_fault | output | 2 | 0 none, 1 limit, 2 not present, 3 permission |
| resp_pte | output | 11 | Entry attributes returned with the answer |

## Verification
The bench targets the boundary of the limit register: page numbers equal to the limit, a limit of zero, and a full limit of sixteen. A comparator that is off by one would translate a page it must refuse, or would issue a stray memory read. Absent entries that carry every permission bit check the fault priority, since a design with the checks swapped would report a permission fault instead of a missing page. Repeated accesses to the same page check that write-back happens only when the referenced or dirty bit actually changes. An always-writing design would show up as a one-cycle-late acknowledge and an extra write. Holding `req` high with a different address during a translation exposes a design that lets a second request in while busy.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_PERM  = 2'd3
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_WBACK,
    ST_RESP
  } st_e;

  // Entry bit positions; the frame number sits above FRAME_LSB.
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_RD      = 1;
  localparam int unsigned BIT_WR      = 2;
  localparam int unsigned BIT_EX      = 3;
  localparam int unsigned BIT_REF     = 4;
  localparam int unsigned BIT_DIRTY   = 5;
  localparam int unsigned BIT_NOCACHE = 6;
  localparam int unsigned FRAME_LSB   = 7;

endpackage

// File: rtl/pt_index.sv
module pt_index #(
  parameter int unsigned PN_W = 4,
  parameter int unsigned MA_W = 16
) (
  input  logic [PN_W-1:0] pn,
  input  logic [MA_W-1:0] base,
  input  logic [PN_W:0]   limit,
  output logic [MA_W-1:0] entry_addr,
  output logic            over_limit
);

  function automatic logic [MA_W-1:0] entry_address(input logic [MA_W-1:0] b,
                                                    input logic [PN_W-1:0] p);
    return b + MA_W'(p);
  endfunction

  function automatic logic beyond(input logic [PN_W-1:0] p, input logic [PN_W:0] l);
    return {1'b0, p} >= l;
  endfunction

  assign entry_addr = entry_address(base, pn);
  assign over_limit = beyond(pn, limit);

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_pkg::*;
#(
  parameter int unsigned PFN_W = 4,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned PTE_W = FRAME_LSB + PFN_W,
  localparam int unsigned PA_W  = PFN_W + OFF_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  input  logic [OFF_W-1:0] offset,
  output logic [1:0]       fault,
  output logic [PTE_W-1:0] new_pte,
  output logic             need_wb,
  output logic [PA_W-1:0]  paddr
);

  function automatic logic allowed(input logic [PTE_W-1:0] e, input logic [1:0] a);
    case (a)
      ACC_READ:  return e[BIT_RD];
      ACC_WRITE: return e[BIT_WR];
      ACC_EXEC:  return e[BIT_EX];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] join_addr(input logic [PFN_W-1:0] frame,
                                                input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction

  function automatic logic [PTE_W-1:0] mark(input logic [PTE_W-1:0] e, input logic [1:0] a);
    logic [PTE_W-1:0] r;
    r = e;
    r[BIT_REF] = 1'b1;
    if (a == ACC_WRITE) r[BIT_DIRTY] = 1'b1;
    return r;
  endfunction

  logic ok;

  always_comb begin
    if (!pte[BIT_PRESENT])   fault = FLT_ABSENT;
    else if (!allowed(pte, acc)) fault = FLT_PERM;
    else                     fault = FLT_NONE;
  end

  assign ok      = (fault == FLT_NONE);
  assign new_pte = ok ? mark(pte, acc) : pte;
  assign need_wb = ok && (new_pte != pte);
  assign paddr   = ok ? join_addr(pte[FRAME_LSB +: PFN_W], offset) : '0;

endmodule

// File: rtl/pt_translator.sv
module pt_translator
  import pt_pkg::*;
#(
  parameter int unsigned VA_W  = 16,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PFN_W = 4,
  parameter int unsigned MA_W  = 16,
  localparam int unsigned PN_W  = VA_W - OFF_W,
  localparam int unsigned PTE_W = FRAME_LSB + PFN_W,
  localparam int unsigned PA_W  = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic [MA_W-1:0]  ptbr,
  input  logic [PN_W:0]    ptlr,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [MA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             ack,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [1:0]       resp_fault,
  output logic [PTE_W-1:0] resp_pte
);

  st_e              state;
  logic [OFF_W-1:0] cur_off;
  logic [1:0]       cur_acc;
  logic [MA_W-1:0]  cur_eaddr;
  logic [1:0]       res_fault;
  logic [PA_W-1:0]  res_paddr;
  logic [PTE_W-1:0] res_pte;

  logic [MA_W-1:0]  idx_addr;
  logic             idx_over;
  logic [1:0]       ev_fault;
  logic [PTE_W-1:0] ev_pte;
  logic             ev_wb;
  logic [PA_W-1:0]  ev_paddr;

  // Named internal events for the checker.
  logic evt_accept;
  logic evt_check;

  assign evt_accept = (state == ST_IDLE) && req;
  assign evt_check  = (state == ST_CHECK);

  pt_index #(.PN_W(PN_W), .MA_W(MA_W)) i_index (
    .pn         (req_vaddr[VA_W-1:OFF_W]),
    .base       (ptbr),
    .limit      (ptlr),
    .entry_addr (idx_addr),
    .over_limit (idx_over)
  );

  pt_entry_eval #(.PFN_W(PFN_W), .OFF_W(OFF_W)) i_eval (
    .pte     (mem_rdata),
    .acc     (cur_acc),
    .offset  (cur_off),
    .fault   (ev_fault),
    .new_pte (ev_pte),
    .need_wb (ev_wb),
    .paddr   (ev_paddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_off   <= '0;
      cur_acc   <= '0;
      cur_eaddr <= '0;
      res_fault <= FLT_NONE;
      res_paddr <= '0;
      res_pte   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (evt_accept) begin
            cur_off   <= req_vaddr[OFF_W-1:0];
            cur_acc   <= req_acc;
            cur_eaddr <= idx_addr;
            if (idx_over) begin
              res_fault <= FLT_LIMIT;
              res_paddr <= '0;
              res_pte   <= '0;
              state     <= ST_RESP;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: state <= ST_CHECK;
        ST_CHECK: begin
          res_fault <= ev_fault;
          res_paddr <= ev_paddr;
          res_pte   <= ev_pte;
          state     <= ev_wb ? ST_WBACK : ST_RESP;
        end
        ST_WBACK: state <= ST_RESP;
        ST_RESP:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en  = (state == ST_FETCH);
  assign mem_wr_en  = (state == ST_WBACK);
  assign mem_addr   = cur_eaddr;
  assign mem_wdata  = res_pte;
  assign ack        = (state == ST_RESP);
  assign resp_paddr = res_paddr;
  assign resp_fault = res_fault;
  assign resp_pte   = res_pte;

endmodule

// File: rtl/pt_checker.sv
module pt_checker
  import pt_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned MA_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [MA_W-1:0]  mem_addr,
  input logic             ack,
  input logic [1:0]       resp_fault,
  input logic [PA_W-1:0]  resp_paddr,
  input logic [OFF_W-1:0] cur_off,
  input logic             evt_accept,
  input logic             evt_check
);

  a_r8_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  a_r7_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r2_read_then_check: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (evt_check && !mem_rd_en));

  a_r6_wb_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> ack);

  a_r6_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $stable(mem_addr));

  a_r3_limit_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && resp_fault == FLT_LIMIT) |-> $past(evt_accept));

  a_r4_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && resp_fault != FLT_NONE) |-> $past(!mem_wr_en));

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && resp_fault == FLT_NONE) |-> (resp_paddr[OFF_W-1:0] == cur_off));

  a_r9_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && resp_fault != FLT_NONE) |-> (resp_paddr == '0));

endmodule

bind pt_translator pt_checker #(.OFF_W(OFF_W), .PA_W(PA_W), .MA_W(MA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .mem_addr   (mem_addr),
  .ack        (ack),
  .resp_fault (resp_fault),
  .resp_paddr (resp_paddr),
  .cur_off    (cur_off),
  .evt_accept (evt_accept),
  .evt_check  (evt_check)
);

// File: tb/test_pt_translator.sv
`timescale 1ns/1ps
module test_pt_translator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [15:0] ptbr = '0;
  logic [4:0]  ptlr = '0;
  logic        mem_rd_en, mem_wr_en, ack;
  logic [15:0] mem_addr, resp_paddr;
  logic [10:0] mem_wdata, resp_pte;
  logic [10:0] mem_rdata = '0;
  logic [1:0]  resp_fault;

  always #2.5 clk = ~clk;

  pt_translator i_pt_translator (
    .clk(clk), .rst_n(rst_n), .req(req), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .ptbr(ptbr), .ptlr(ptlr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ack(ack),
    .resp_paddr(resp_paddr), .resp_fault(resp_fault), .resp_pte(resp_pte)
  );

  // Bench memory, plus a side port used for setup.
  logic [10:0] mem [0:255];
  logic [10:0] ref_mem [0:255];
  logic        set_en = 1'b0;
  logic [7:0]  set_addr = '0;
  logic [10:0] set_data = '0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [15:0] last_rd_addr = '0, last_wr_addr = '0;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata    <= mem[mem_addr[7:0]];
      rd_cnt       <= rd_cnt + 1;
      last_rd_addr <= mem_addr;
    end
    if (mem_wr_en) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt       <= wr_cnt + 1;
      last_wr_addr <= mem_addr;
    end
    if (set_en) mem[set_addr] <= set_data;
  end

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Entry: {frame[3:0], nocache, dirty, ref, x, w, r, present}
  function automatic logic [10:0] ent(input int frame, input bit nc, input bit d, input bit rf,
                                      input bit x, input bit w, input bit r, input bit p);
    return {frame[3:0], nc, d, rf, x, w, r, p};
  endfunction

  task automatic poke(input int a, input logic [10:0] v);
    @(negedge clk);
    set_en = 1'b1; set_addr = a[7:0]; set_data = v;
    @(negedge clk);
    set_en = 1'b0;
    ref_mem[a] = v;
  endtask

  // Reference outcome of one translation, written from the requirements.
  task automatic xlate(input logic [15:0] va, input logic [1:0] acc, input bit hold_busy,
                       input string tag);
    int pn, ea, lat, rd0, wr0, exp_fault, exp_paddr, exp_pte;
    bit okperm, wb, ack_ok;
    logic [10:0] e, ne;
    pn = int'(va[15:12]);
    ea = int'(ptbr) + pn;
    wb = 0;
    exp_paddr = 0;
    exp_pte = 0;
    if (pn >= int'(ptlr)) begin
      exp_fault = 1; lat = 1;
    end else begin
      e = ref_mem[ea];
      exp_pte = int'(e);
      lat = 3;
      if (!e[0]) exp_fault = 2;
      else begin
        okperm = (acc == 2'd0) ? e[1] : (acc == 2'd1) ? e[2] : (acc == 2'd2) ? e[3] : 1'b0;
        if (!okperm) exp_fault = 3;
        else begin
          exp_fault = 0;
          ne = e;
          ne[4] = 1'b1;
          if (acc == 2'd1) ne[5] = 1'b1;
          wb = (ne != e);
          if (wb) lat = 4;
          ref_mem[ea] = ne;
          exp_pte = int'(ne);
          exp_paddr = int'(e[10:7]) * 4096 + int'(va[11:0]);
        end
      end
    end
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req = 1'b1; req_vaddr = va; req_acc = acc;
    ack_ok = 1;
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      if (n == 1 && !hold_busy) req = 1'b0;
      if (n == 1 && hold_busy) begin req_vaddr = va ^ 16'hF0F0; req_acc = 2'd1; end
      if (ack !== (n == lat)) ack_ok = 0;
      if (n == lat) begin
        chk(resp_fault == exp_fault[1:0], {tag, " R3/R4/R5 fault code"}, resp_fault, exp_fault);
        chk(resp_paddr == exp_paddr[15:0], {tag, " R1 physical address"}, resp_paddr, exp_paddr);
        chk(resp_pte == exp_pte[10:0], {tag, " R9 returned entry"}, resp_pte, exp_pte);
        req = 1'b0;
      end
    end
    chk(ack_ok, {tag, " R7 ack timing"}, ack_ok, 1);
    chk(rd_cnt - rd0 == ((lat == 1) ? 0 : 1), {tag, " R2 read count"}, rd_cnt - rd0, (lat == 1) ? 0 : 1);
    if (lat != 1) chk(last_rd_addr == ea[15:0], {tag, " R2 entry address"}, last_rd_addr, ea);
    chk(wr_cnt - wr0 == (wb ? 1 : 0), {tag, " R6 write-back count"}, wr_cnt - wr0, wb ? 1 : 0);
    if (wb) chk(last_wr_addr == ea[15:0], {tag, " R6 write-back address"}, last_wr_addr, ea);
    if (ea < 256) chk(mem[ea] == ref_mem[ea], {tag, " R6 stored entry"}, mem[ea], ref_mem[ea]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!ack && !mem_rd_en && !mem_wr_en, "R8 outputs during reset", {ack, mem_rd_en, mem_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack && !mem_rd_en && !mem_wr_en, "R8 idle after reset", {ack, mem_rd_en, mem_wr_en}, 0);

    ptbr = 16'h0040; ptlr = 5'd16;
    poke(16'h43, ent(9, 0, 0, 0, 0, 0, 1, 1));
    poke(16'h45, ent(12, 1, 0, 0, 0, 1, 1, 1));
    poke(16'h47, ent(2, 0, 0, 0, 1, 1, 1, 0));
    poke(16'h48, ent(5, 0, 0, 0, 1, 0, 0, 1));
    poke(16'h40, ent(1, 0, 0, 0, 0, 0, 1, 1));
    poke(16'h4F, ent(15, 0, 1, 1, 1, 1, 1, 1));

    xlate(16'h3005, 2'd0, 0, "R1 example read");
    xlate(16'h3FFF, 2'd0, 0, "R6 repeat read no wb");
    xlate(16'h3010, 2'd1, 0, "R5 write refused");
    xlate(16'h5ABC, 2'd1, 0, "R6 write sets dirty");
    xlate(16'h5ABD, 2'd0, 0, "R6 read after write");
    xlate(16'h7123, 2'd0, 0, "R4 absent with perms");
    xlate(16'h7123, 2'd3, 0, "R4 absent reserved");
    xlate(16'h8001, 2'd2, 0, "R5 execute allowed");
    xlate(16'h8001, 2'd0, 0, "R5 read without bit");
    xlate(16'h0000, 2'd3, 0, "R5 reserved code");
    xlate(16'hFFFF, 2'd1, 0, "R3 full limit last page");
    xlate(16'h9000, 2'd0, 0, "R4 zero entry");
    xlate(16'h3444, 2'd0, 1, "R7 busy request ignored");
    chk(!ack, "R7 idle after held request", ack, 0);

    ptlr = 5'd6;
    xlate(16'h6000, 2'd0, 0, "R3 page equals limit");
    xlate(16'h5001, 2'd1, 0, "R3 page below limit");
    ptlr = 5'd0;
    xlate(16'h0002, 2'd0, 0, "R3 zero limit");

    ptbr = 16'h00A0; ptlr = 5'd16;
    poke(16'hA3, ent(4, 1, 0, 0, 1, 0, 0, 1));
    xlate(16'h3777, 2'd2, 0, "R2 other base exec");
    xlate(16'h3777, 2'd1, 0, "R2 other base write");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule